// File: doc/BRIEF.md
# Cyclic Timed Instruction Sequencer

This controller sits beside one processing element and steps it through a small instruction store of 64-bit words. Each fetched word is held in an instruction register for a duration that the word itself programs, from 1 to 16 enabled cycles. When that time runs out, the sequencer loads the next word. The word names its own successor as an offset from its own address. It also carries a valid address window, and the address falls back to the start of that window instead of running past it. A short group of words therefore replays periodically without outside help.

The held word is split into a datapath control field, an input delay, an output delay, an 11-bit network routing field and a 7-bit field reserved for later use. All of them drive the element and its routers directly. The store has two context banks. A change of the bank selector waits for the current word to expire, and the new bank then starts at word 0. A low run enable freezes everything: the controls, the remaining hold time and the fetch address. The instruction store is external, with a combinational read port. Loading the store and the datapath itself are outside this block.

Top module: `cyc_instr_seq`

## Requirements
- R1: During reset `ctl_valid` is 0, every control output is 0, and the fetch address `mem_addr` is 0.
- R2: The first clock edge with `run_en` high after reset loads word 0 of the bank on `bank_sel`. From that edge on, `ctl_valid` is 1.
- R3: Bits [3:0] of a word hold a value d. The word stays in the instruction register for d+1 edges with `run_en` high, which gives 1 to 16 cycles.
- R4: Bits [8:5] hold an unsigned offset. The successor address is the current address plus this offset, so an offset of 0 repeats the same word.
- R5: When bit 4 (the wrap flag) is set, the successor is the window start held in bits [13:9].
- R6: The window end in bits [18:14] is exclusive. When current address plus offset is at or beyond the window end, or at or beyond the store depth, the successor is the window start.
- R7: When `bank_sel` differs from the bank of the current word, the next load comes from address 0 of the newly selected bank. The switch happens only when the current word expires, never part way through its hold time.
- R8: While `run_en` is low, the control outputs, `ctl_valid` and the remaining hold time do not change. The count resumes where it stopped.
- R9: The outputs are taken from fixed fields of the held word: `dp_ctl` from [37:19], `in_dly` from [41:38], `out_dly` from [45:42], `noc_ctl` from [56:46] and `rsvd_ctl` from [63:57].
- R10: `mem_addr` is always below the store depth. A window start outside the store is treated as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Advance enable; when low, all state is frozen |
| bank_sel | input | BANK_W | Context bank to use from the next instruction boundary |
| mem_bank | output | BANK_W | Bank of the word being fetched |
| mem_addr | output | 5 | Address of the word being fetched |
| mem_rdata | input | 64 | Combinational read data of the instruction store |
| ctl_valid | output | 1 | A word has been loaded since reset |
| dp_ctl | output | 19 | Datapath and operation controls |
| in_dly | output | 4 | Input delay setting |
| out_dly | output | 4 | Output delay setting |
| noc_ctl | output | 11 | Network routing control |
| rsvd_ctl | output | 7 | Reserved field, passed through unchanged |

## Verification
The tests use short programs in which every word carries a distinct tag in its datapath field, so the tag seen on `dp_ctl` cycle by cycle shows both which word is active and how long it has been held. Each program targets one mechanism:
- a three-word loop with mixed durations shows whether the hold count is off by one;
- a windowed program, and one that runs past the store depth, separate the window-end fallback from the depth clamp and from the explicit wrap flag;
- a maximum-duration word followed by a self-repeating word exercises the full 16-cycle hold and the zero offset;
- a stall in the middle of a hold shows whether the remaining time is kept or restarted;
- a bank change made in the middle of a hold shows whether the switch waits for the boundary.

A word with distinct values in every field confirms the field positions.

// File: rtl/tseq_pkg.sv
`timescale 1ns/1ps
package tseq_pkg;
  localparam int WORD_W = 64;
  localparam int PTR_W  = 5;   // width of address-type fields inside the word
  localparam int DUR_W  = 4;
  localparam int OFF_W  = 4;
  localparam int DP_W   = 19;
  localparam int DLY_W  = 4;
  localparam int NOC_W  = 11;
  localparam int RSV_W  = 7;

  // Most significant field first; bit 0 is the low end of the duration.
  typedef struct packed {
    logic [RSV_W-1:0] rsvd;
    logic [NOC_W-1:0] noc;
    logic [DLY_W-1:0] out_dly;
    logic [DLY_W-1:0] in_dly;
    logic [DP_W-1:0]  dp;
    logic [PTR_W-1:0] win_end;
    logic [PTR_W-1:0] win_start;
    logic [OFF_W-1:0] step;
    logic             wrap;
    logic [DUR_W-1:0] dur;
  } tseq_word_t;
endpackage

// File: rtl/tseq_next_addr.sv
`timescale 1ns/1ps
module tseq_next_addr
  import tseq_pkg::*;
#(
  parameter int DEPTH  = 20,
  parameter int BANK_W = 1
) (
  input  logic              loaded,
  input  logic [PTR_W-1:0]  cur_addr,
  input  logic [BANK_W-1:0] cur_bank,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [OFF_W-1:0]  step,
  input  logic              wrap,
  input  logic [PTR_W-1:0]  win_start,
  input  logic [PTR_W-1:0]  win_end,
  output logic [PTR_W-1:0]  fetch_addr
);
  localparam logic [PTR_W:0] DEPTH_V = (PTR_W+1)'(DEPTH);

  logic [PTR_W:0]   sum;
  logic [PTR_W-1:0] start;
  logic             past_end;
  logic             restart;

  always_comb begin
    sum      = {1'b0, cur_addr} + {{(PTR_W+1-OFF_W){1'b0}}, step};
    start    = ({1'b0, win_start} < DEPTH_V) ? win_start : '0;
    past_end = wrap || (sum >= {1'b0, win_end}) || (sum >= DEPTH_V);
    restart  = !loaded || (bank_sel != cur_bank);
    if (restart)       fetch_addr = '0;
    else if (past_end) fetch_addr = start;
    else               fetch_addr = sum[PTR_W-1:0];
  end
endmodule

// File: rtl/tseq_hold_timer.sv
`timescale 1ns/1ps
module tseq_hold_timer
  import tseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [DUR_W-1:0] load_val,
  output logic             zero
);
  logic [DUR_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   remain <= '0;
    else if (load)                remain <= load_val;
    else if (adv && remain != '0) remain <= remain - 1'b1;
  end

  assign zero = (remain == '0);
endmodule

// File: rtl/tseq_field_split.sv
`timescale 1ns/1ps
module tseq_field_split
  import tseq_pkg::*;
(
  input  tseq_word_t       word,
  output logic [DP_W-1:0]  dp_ctl,
  output logic [DLY_W-1:0] in_dly,
  output logic [DLY_W-1:0] out_dly,
  output logic [NOC_W-1:0] noc_ctl,
  output logic [RSV_W-1:0] rsvd_ctl
);
  assign dp_ctl   = word.dp;
  assign in_dly   = word.in_dly;
  assign out_dly  = word.out_dly;
  assign noc_ctl  = word.noc;
  assign rsvd_ctl = word.rsvd;
endmodule

// File: rtl/cyc_instr_seq.sv
`timescale 1ns/1ps
module cyc_instr_seq
  import tseq_pkg::*;
#(
  parameter int DEPTH   = 20,
  parameter int NBANKS  = 2,
  localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [BANK_W-1:0] mem_bank,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              ctl_valid,
  output logic [DP_W-1:0]   dp_ctl,
  output logic [DLY_W-1:0]  in_dly,
  output logic [DLY_W-1:0]  out_dly,
  output logic [NOC_W-1:0]  noc_ctl,
  output logic [RSV_W-1:0]  rsvd_ctl
);
  tseq_word_t        ir;
  tseq_word_t        fetched;
  logic [PTR_W-1:0]  cur_addr;
  logic [BANK_W-1:0] cur_bank;
  logic              loaded;
  logic              tmr_zero;
  logic              expire;
  logic [PTR_W-1:0]  fetch_addr;

  assign fetched = tseq_word_t'(mem_rdata);
  assign expire  = run_en && (!loaded || tmr_zero);

  tseq_next_addr #(.DEPTH(DEPTH), .BANK_W(BANK_W)) u_next (
    .loaded    (loaded),
    .cur_addr  (cur_addr),
    .cur_bank  (cur_bank),
    .bank_sel  (bank_sel),
    .step      (ir.step),
    .wrap      (ir.wrap),
    .win_start (ir.win_start),
    .win_end   (ir.win_end),
    .fetch_addr(fetch_addr)
  );

  tseq_hold_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (run_en),
    .load    (expire),
    .load_val(fetched.dur),
    .zero    (tmr_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir       <= '0;
      cur_addr <= '0;
      cur_bank <= '0;
      loaded   <= 1'b0;
    end else if (expire) begin
      ir       <= fetched;
      cur_addr <= fetch_addr;
      cur_bank <= bank_sel;
      loaded   <= 1'b1;
    end
  end

  assign mem_addr  = fetch_addr;
  assign mem_bank  = bank_sel;
  assign ctl_valid = loaded;

  tseq_field_split u_split (
    .word    (ir),
    .dp_ctl  (dp_ctl),
    .in_dly  (in_dly),
    .out_dly (out_dly),
    .noc_ctl (noc_ctl),
    .rsvd_ctl(rsvd_ctl)
  );
endmodule

// File: rtl/cyc_instr_seq_chk.sv
`timescale 1ns/1ps
module cyc_instr_seq_chk #(
  parameter int DEPTH  = 20,
  parameter int BANK_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic [BANK_W-1:0] bank_sel,
  input logic [BANK_W-1:0] mem_bank,
  input logic [4:0]        mem_addr,
  input logic              ctl_valid,
  input logic [18:0]       dp_ctl,
  input logic [10:0]       noc_ctl,
  input logic              tmr_zero,
  input logic [BANK_W-1:0] cur_bank,
  input logic              wrap_flag,
  input logic [4:0]        range_lo
);
  // R2: first enabled edge produces a valid word
  a_r2_first_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_valid && run_en) |=> ctl_valid);

  // R3: no change of controls before the hold time runs out
  a_r3_hold_time: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && ctl_valid && !tmr_zero) |=> ($stable(dp_ctl) && $stable(noc_ctl)));

  // R5: wrap flag sends the fetch to the window start
  a_r5_wrap_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && bank_sel == cur_bank && wrap_flag && range_lo < 5'(DEPTH))
      |-> mem_addr == range_lo);

  // R7: a bank change fetches word 0 of the new bank
  a_r7_bank_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && bank_sel != cur_bank) |-> (mem_addr == 5'd0 && mem_bank == bank_sel));

  // R8: stalled cycles leave everything unchanged
  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ($stable(dp_ctl) && $stable(noc_ctl) && $stable(ctl_valid)));

  // R10: fetch address stays inside the store
  a_r10_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(mem_addr) < DEPTH);
endmodule

bind cyc_instr_seq cyc_instr_seq_chk #(.DEPTH(DEPTH), .BANK_W(BANK_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .bank_sel (bank_sel),
  .mem_bank (mem_bank),
  .mem_addr (mem_addr),
  .ctl_valid(ctl_valid),
  .dp_ctl   (dp_ctl),
  .noc_ctl  (noc_ctl),
  .tmr_zero (tmr_zero),
  .cur_bank (cur_bank),
  .wrap_flag(ir.wrap),
  .range_lo (ir.win_start)
);

// File: tb/test_cyc_instr_seq.sv
`timescale 1ns/1ps
module test_cyc_instr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic [0:0]  bank_sel = 1'b0;
  logic [0:0]  mem_bank;
  logic [4:0]  mem_addr;
  logic [63:0] mem_rdata;
  logic        ctl_valid;
  logic [18:0] dp_ctl;
  logic [3:0]  in_dly, out_dly;
  logic [10:0] noc_ctl;
  logic [6:0]  rsvd_ctl;

  logic [63:0] mem [2][20];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;   // 20 ns period, 50 MHz

  assign mem_rdata = mem[mem_bank][mem_addr];

  cyc_instr_seq i_cyc_instr_seq (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .bank_sel(bank_sel),
    .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .ctl_valid(ctl_valid), .dp_ctl(dp_ctl), .in_dly(in_dly), .out_dly(out_dly),
    .noc_ctl(noc_ctl), .rsvd_ctl(rsvd_ctl)
  );

  // word layout: dur[3:0] wrap[4] step[8:5] lo[13:9] hi[18:14] dp[37:19]
  function automatic logic [63:0] mk(int d, int w, int off, int lo, int hi, int tag);
    return {7'h0, 11'(tag), 4'h0, 4'h0, 19'(tag), 5'(hi), 5'(lo), 4'(off), 1'(w), 4'(d)};
  endfunction

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic exp_tag(input string req, input int t);
    @(negedge clk);
    chk(req, "dp_ctl", longint'(dp_ctl), longint'(t));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run_en = 1'b0; bank_sel = 1'b0;
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 20; a++) mem[b][a] = 64'h0;
    @(negedge clk);
  endtask

  task automatic go();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_en = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "ctl_valid", ctl_valid, 0);
    chk("R1", "dp_ctl", dp_ctl, 0);
    chk("R1", "noc_ctl", noc_ctl, 0);
    chk("R1", "mem_addr", mem_addr, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "ctl_valid idle", ctl_valid, 0);
  endtask

  task automatic t_loop();
    do_reset();
    mem[0][0] = mk(2, 0, 1, 0, 20, 10);
    mem[0][1] = mk(0, 0, 1, 0, 20, 11);
    mem[0][2] = mk(0, 1, 0, 0, 20, 12);
    go();
    exp_tag("R2", 10);
    chk("R2", "ctl_valid", ctl_valid, 1);
    exp_tag("R3", 10); exp_tag("R3", 10);
    exp_tag("R4", 11); exp_tag("R4", 12);
    exp_tag("R5", 10); exp_tag("R3", 10); exp_tag("R3", 10); exp_tag("R4", 11);
  endtask

  task automatic t_window();
    do_reset();
    mem[0][0] = mk(0, 0, 4, 0, 20, 20);
    mem[0][4] = mk(0, 0, 2, 4, 8, 24);
    mem[0][6] = mk(0, 0, 2, 4, 8, 26);
    go();
    exp_tag("R4", 20); exp_tag("R4", 24); exp_tag("R6", 26);
    chk("R6", "mem_addr", mem_addr, 4);
    exp_tag("R6", 24); exp_tag("R6", 26);
  endtask

  task automatic t_depth();
    do_reset();
    mem[0][0]  = mk(0, 0, 15, 3, 31, 40);
    mem[0][15] = mk(0, 0, 4, 3, 31, 45);
    mem[0][19] = mk(0, 0, 1, 3, 31, 49);
    mem[0][3]  = mk(0, 0, 12, 3, 31, 43);
    go();
    exp_tag("R4", 40); exp_tag("R4", 45); exp_tag("R10", 49);
    chk("R10", "mem_addr", mem_addr, 3);
    exp_tag("R6", 43); exp_tag("R6", 45);
  endtask

  task automatic t_long();
    do_reset();
    mem[0][0] = mk(15, 0, 1, 0, 20, 30);
    mem[0][1] = mk(0, 0, 0, 0, 20, 31);
    go();
    for (int i = 0; i < 16; i++) exp_tag("R3", 30);
    exp_tag("R3", 31); exp_tag("R4", 31); exp_tag("R4", 31);
  endtask

  task automatic t_freeze();
    do_reset();
    mem[0][0] = mk(2, 0, 1, 0, 20, 70);
    mem[0][1] = mk(0, 1, 0, 0, 20, 71);
    go();
    exp_tag("R8", 70);
    run_en = 1'b0;
    for (int i = 0; i < 4; i++) exp_tag("R8", 70);
    chk("R8", "ctl_valid", ctl_valid, 1);
    run_en = 1'b1;
    exp_tag("R8", 70); exp_tag("R8", 70); exp_tag("R8", 71);
  endtask

  task automatic t_bank();
    do_reset();
    mem[0][0] = mk(1, 0, 1, 0, 20, 50);
    mem[0][1] = mk(0, 1, 0, 0, 20, 51);
    mem[1][0] = mk(0, 0, 1, 0, 20, 60);
    mem[1][1] = mk(0, 1, 0, 0, 20, 61);
    go();
    exp_tag("R7", 50);
    bank_sel = 1'b1;
    exp_tag("R7", 50);
    exp_tag("R7", 60);
    chk("R7", "mem_bank", mem_bank, 1);
    exp_tag("R7", 61); exp_tag("R7", 60);
  endtask

  task automatic t_fields();
    do_reset();
    mem[0][0] = {7'h5B, 11'h6B1, 4'hC, 4'h3, 19'h5A5A5, 5'd20, 5'd0, 4'd0, 1'b1, 4'd0};
    go();
    @(negedge clk);
    chk("R9", "dp_ctl", dp_ctl, 19'h5A5A5);
    chk("R9", "in_dly", in_dly, 4'h3);
    chk("R9", "out_dly", out_dly, 4'hC);
    chk("R9", "noc_ctl", noc_ctl, 11'h6B1);
    chk("R9", "rsvd_ctl", rsvd_ctl, 7'h5B);
  endtask

  initial begin
    t_reset();
    t_loop();
    t_window();
    t_depth();
    t_long();
    t_freeze();
    t_bank();
    t_fields();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule